// File: doc/BRIEF.md
# PHY Power-Up Sequencer with Lock Wait

This block powers a display PHY up and down. It drives two power-down lines, one for the PLL and one for the lane circuitry, plus a reference-clock enable and an LVDS enable. A power-on request starts a mode-dependent sequence. In serial D-PHY mode the PLL is released first, then the block waits for PLL lock, then it releases the lanes. In LVDS mode the LVDS enable is set, then the lanes are released, then the PLL. After that the block waits for lock, unless it is configured as a slave. A slave finishes without waiting.

Lock is sampled on a coarse grid of microsecond ticks. If it has not appeared within a bounded window, the block shuts everything off again and raises a sticky error. Each sequence that succeeds, and each accepted power-off or init request, ends with a one-cycle done pulse. Requests that arrive while a sequence is running are dropped. The analog PHY and any register access are outside this block.

Top module: `phy_pwr_seq`

## Requirements
- R1: While reset is asserted and right after it, both power-down outputs are 1 (off), and the LVDS enable, the reference-clock enable, done and error are all 0.
- R2: An on request accepted in the off state sets the reference-clock enable on the next clock edge. No power-down line is released and no LVDS enable is set unless the reference-clock enable is already 1.
- R3: D-PHY mode (mode input 0) works as follows. The PLL power-down falls one edge after the reference-clock enable rises. The lane power-down falls only on the edge where lock is sampled high, and done pulses on that same edge.
- R4: During the wait, lock is sampled only on every POLL_TICKS-th microsecond tick, counted from entry into the wait. A lock pulse that falls between two samples has no effect.
- R5: The wait expires on the TIMEOUT_TICKS-th tick. If lock is low then, the next edge returns all four control outputs to the off state and sets the error flag, with no done pulse. If lock is high at that final sample, the sequence succeeds.
- R6: LVDS mode (mode input 1) sets the LVDS enable, then releases the lane power-down, then the PLL power-down, one clock edge apart.
- R7: LVDS mode without the slave flag then waits for lock exactly as in R4 and R5, and pulses done on success without changing any output.
- R8: LVDS mode with the slave flag pulses done on the same edge that releases the PLL power-down. It never waits for lock and never reports an error.
- R9: An off request while the block is off or fully on drives both power-down lines to 1 and clears the LVDS and reference-clock enables on the next edge, with a done pulse.
- R10: An init request behaves like an off request: both power-down lines go to 1 on the next edge, with a done pulse.
- R11: On, off and init requests that arrive while a sequence is in progress leave every output unchanged.
- R12: The error flag stays set across later idle cycles and off requests. It clears only on the edge that accepts the next on request.
- R13: The mode and slave inputs are captured when an on request is accepted. Later changes do not alter the running sequence, and in D-PHY mode the LVDS enable never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_req | input | 1 | Request a power-up sequence |
| off_req | input | 1 | Request power-down |
| init_req | input | 1 | Request the initial off state |
| mode_lvds | input | 1 | 0 = D-PHY mode, 1 = LVDS mode |
| slave_en | input | 1 | LVDS slave: skip the lock wait |
| pll_lock | input | 1 | PLL lock indication |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pll_pwrdn | output | 1 | PLL power-down, 1 = off |
| lane_pwrdn | output | 1 | Lane power-down, 1 = off |
| lvds_en | output | 1 | LVDS output enable |
| refclk_en | output | 1 | Reference-clock enable |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_err | output | 1 | Sticky lock-timeout error |

## Verification
Assertions check the following on every cycle:
- a power-down line is never released unless the reference clock is enabled;
- in D-PHY mode the lane release always follows an already released PLL, and in LVDS mode the PLL release follows the lanes;
- an LVDS slave finishes on the same edge that releases the PLL;
- a rising error finds all controls in the off state;
- a timeout only coincides with a lock sample.

Only the bench scenarios can show the exact timing of the lock samples. They cover lock pulses that fall between samples, the race between a final-sample lock and the timeout, that busy-time requests are dropped, and that the error stays set until the next power-on.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

   typedef enum logic [2:0] {
      SEQ_OFF  = 3'd0,
      SEQ_CLK  = 3'd1,
      SEQ_LVEN = 3'd2,
      SEQ_LANE = 3'd3,
      SEQ_WAIT = 3'd4,
      SEQ_ON   = 3'd5
   } seq_state_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_UP   = 2'd1,
      CMD_DOWN = 2'd2
   } seq_cmd_e;

   typedef struct packed {
      logic pll_pd;
      logic lane_pd;
      logic lvds_en;
      logic refclk_en;
   } pwr_ctl_t;

   localparam pwr_ctl_t PWR_SAFE = '{pll_pd: 1'b1, lane_pd: 1'b1,
                                     lvds_en: 1'b0, refclk_en: 1'b0};

endpackage

// File: rtl/phy_lock_timer.sv
module phy_lock_timer #(
   parameter int POLL_TICKS    = 10,
   parameter int TIMEOUT_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic us_tick,
   output logic sample_stb,
   output logic expired_stb
);
   localparam int EW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

   logic [EW-1:0] elapsed_q;
   logic          tick_en;

   assign tick_en = run && us_tick;

   // elapsed microseconds inside the current wait
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       elapsed_q <= '0;
      else if (!run)    elapsed_q <= '0;
      else if (tick_en) elapsed_q <= elapsed_q + 1'b1;
   end

   assign expired_stb = tick_en && (elapsed_q == EW'(TIMEOUT_TICKS - 1));

   generate
      if (POLL_TICKS == 1) begin : g_every_tick
         assign sample_stb = tick_en;
      end else begin : g_poll_div
         localparam int PW = $clog2(POLL_TICKS);
         logic [PW-1:0] poll_q;
         logic          poll_last;

         assign poll_last = (poll_q == PW'(POLL_TICKS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       poll_q <= '0;
            else if (!run)    poll_q <= '0;
            else if (tick_en) poll_q <= poll_last ? '0 : poll_q + 1'b1;
         end

         assign sample_stb = tick_en && poll_last;
      end
   endgenerate

   // R5
   expire_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired_stb |-> sample_stb)
      else $error("timeout fired between lock samples");

endmodule

// File: rtl/phy_req_gate.sv
module phy_req_gate
   import phy_pwr_pkg::*;
(
   input  logic     on_req,
   input  logic     off_req,
   input  logic     init_req,
   input  logic     at_off,
   input  logic     at_on,
   output seq_cmd_e cmd
);
   logic idle;
   assign idle = at_off || at_on;

   // power-down wins over power-up; nothing is taken while busy
   always_comb begin
      cmd = CMD_NONE;
      if (idle && (off_req || init_req)) cmd = CMD_DOWN;
      else if (at_off && on_req)         cmd = CMD_UP;
   end

endmodule

// File: rtl/phy_pwr_fsm.sv
module phy_pwr_fsm
   import phy_pwr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  seq_cmd_e cmd,
   input  logic     mode_lvds,
   input  logic     slave_en,
   input  logic     pll_lock,
   input  logic     sample_stb,
   input  logic     expired_stb,
   output pwr_ctl_t ctl,
   output logic     done,
   output logic     err,
   output logic     timer_run,
   output logic     at_off,
   output logic     at_on
);
   seq_state_e state_q;
   pwr_ctl_t   ctl_q;
   logic       done_q, err_q, lvds_q, slave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_OFF;
         ctl_q   <= PWR_SAFE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         lvds_q  <= 1'b0;
         slave_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_OFF, SEQ_ON: begin
               if (cmd == CMD_DOWN) begin
                  ctl_q   <= PWR_SAFE;
                  state_q <= SEQ_OFF;
                  done_q  <= 1'b1;
               end else if (cmd == CMD_UP) begin
                  lvds_q          <= mode_lvds;
                  slave_q         <= slave_en;
                  err_q           <= 1'b0;
                  ctl_q.refclk_en <= 1'b1;
                  state_q         <= SEQ_CLK;
               end
            end
            SEQ_CLK: begin
               if (lvds_q) begin
                  ctl_q.lvds_en <= 1'b1;
                  state_q       <= SEQ_LVEN;
               end else begin
                  ctl_q.pll_pd <= 1'b0;
                  state_q      <= SEQ_WAIT;
               end
            end
            SEQ_LVEN: begin
               ctl_q.lane_pd <= 1'b0;
               state_q       <= SEQ_LANE;
            end
            SEQ_LANE: begin
               ctl_q.pll_pd <= 1'b0;
               if (slave_q) begin
                  state_q <= SEQ_ON;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               if (sample_stb && pll_lock) begin
                  if (!lvds_q) ctl_q.lane_pd <= 1'b0;
                  state_q <= SEQ_ON;
                  done_q  <= 1'b1;
               end else if (expired_stb) begin
                  ctl_q   <= PWR_SAFE;
                  err_q   <= 1'b1;
                  state_q <= SEQ_OFF;
               end
            end
            default: begin
               ctl_q   <= PWR_SAFE;
               state_q <= SEQ_OFF;
            end
         endcase
      end
   end

   assign ctl       = ctl_q;
   assign done      = done_q;
   assign err       = err_q;
   assign timer_run = (state_q == SEQ_WAIT);
   assign at_off    = (state_q == SEQ_OFF);
   assign at_on     = (state_q == SEQ_ON);

   // R2
   refclk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.pll_pd || !ctl_q.lane_pd || ctl_q.lvds_en) |-> ctl_q.refclk_en)
      else $error("power released without reference clock");

   // R3
   dphy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_q.lane_pd) && !lvds_q) |-> !$past(ctl_q.pll_pd))
      else $error("lanes released before PLL in D-PHY mode");

   // R6
   lvds_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_q.pll_pd) && lvds_q) |-> (!$past(ctl_q.lane_pd) && ctl_q.lvds_en))
      else $error("PLL released before lanes in LVDS mode");

   // R8
   slave_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_q.pll_pd) && lvds_q && slave_q) |-> done_q)
      else $error("slave sequence did not finish with PLL release");

   // R5
   err_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (ctl_q == PWR_SAFE && !done_q))
      else $error("error raised with power still applied");

   // R13
   dphy_no_lvds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lvds_q |-> !ctl_q.lvds_en)
      else $error("LVDS enable set in D-PHY mode");

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
   import phy_pwr_pkg::*;
#(
   parameter int POLL_TICKS    = 10,
   parameter int TIMEOUT_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   input  logic init_req,
   input  logic mode_lvds,
   input  logic slave_en,
   input  logic pll_lock,
   input  logic us_tick,
   output logic pll_pwrdn,
   output logic lane_pwrdn,
   output logic lvds_en,
   output logic refclk_en,
   output logic seq_done,
   output logic seq_err
);
   initial begin
      poll_param_chk: assert (POLL_TICKS >= 1)
         else $error("POLL_TICKS must be at least 1");
      window_param_chk: assert (TIMEOUT_TICKS >= POLL_TICKS
                                && (TIMEOUT_TICKS % POLL_TICKS) == 0)
         else $error("TIMEOUT_TICKS must be a multiple of POLL_TICKS");
   end

   seq_cmd_e cmd;
   pwr_ctl_t ctl;
   logic     timer_run, sample_stb, expired_stb, at_off, at_on;

   phy_req_gate u_gate (
      .on_req   (on_req),
      .off_req  (off_req),
      .init_req (init_req),
      .at_off   (at_off),
      .at_on    (at_on),
      .cmd      (cmd)
   );

   phy_lock_timer #(
      .POLL_TICKS    (POLL_TICKS),
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (timer_run),
      .us_tick     (us_tick),
      .sample_stb  (sample_stb),
      .expired_stb (expired_stb)
   );

   phy_pwr_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (cmd),
      .mode_lvds   (mode_lvds),
      .slave_en    (slave_en),
      .pll_lock    (pll_lock),
      .sample_stb  (sample_stb),
      .expired_stb (expired_stb),
      .ctl         (ctl),
      .done        (seq_done),
      .err         (seq_err),
      .timer_run   (timer_run),
      .at_off      (at_off),
      .at_on       (at_on)
   );

   assign pll_pwrdn  = ctl.pll_pd;
   assign lane_pwrdn = ctl.lane_pd;
   assign lvds_en    = ctl.lvds_en;
   assign refclk_en  = ctl.refclk_en;

endmodule

// File: tb/tb_phy_pwr_seq.sv
`timescale 1ns/100ps
module tb_phy_pwr_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic on_req = 1'b0, off_req = 1'b0, init_req = 1'b0;
   logic mode_lvds = 1'b0, slave_en = 1'b0, pll_lock = 1'b0, us_tick = 1'b1;
   logic pll_pwrdn, lane_pwrdn, lvds_en, refclk_en, seq_done, seq_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [5:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   phy_pwr_seq dut (
      .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
      .init_req(init_req), .mode_lvds(mode_lvds), .slave_en(slave_en),
      .pll_lock(pll_lock), .us_tick(us_tick), .pll_pwrdn(pll_pwrdn),
      .lane_pwrdn(lane_pwrdn), .lvds_en(lvds_en), .refclk_en(refclk_en),
      .seq_done(seq_done), .seq_err(seq_err)
   );

   // {pll_pd, lane_pd, lvds_en, refclk_en, done, err}
   function automatic logic [5:0] v(input bit p, input bit l, input bit e,
                                    input bit r, input bit d, input bit x);
      return {p, l, e, r, d, x};
   endfunction

   localparam logic [5:0] OFFV = 6'b110000;

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [5:0] e;
         logic [5:0] got;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         got = {pll_pwrdn, lane_pwrdn, lvds_en, refclk_en, seq_done, seq_err};
         checks++;
         if (got !== e) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", t, got, e, $time);
         end
      end
   end

   task automatic cyc(input logic [5:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      #1;
   endtask

   task automatic hold(input int n, input logic [5:0] e, input string t);
      for (int i = 0; i < n; i++) cyc(e, t);
   endtask

   localparam logic [5:0] CLKV  = 6'b110100;
   localparam logic [5:0] WAITV = 6'b010100;

   initial begin
      @(negedge clk); #1;
      cyc(OFFV, "R1");            // during reset
      rst_n = 1'b1;
      cyc(OFFV, "R1");

      // D-PHY, lock already present (R2, R3)
      mode_lvds = 0; pll_lock = 1; on_req = 1;
      cyc(CLKV, "R2");
      on_req = 0;
      cyc(WAITV, "R3");
      hold(9, WAITV, "R3");
      cyc(v(0,0,0,1,1,0), "R3");
      cyc(v(0,0,0,1,0,0), "R3");
      off_req = 1;
      cyc(v(1,1,0,0,1,0), "R9");
      off_req = 0;
      cyc(OFFV, "R9");

      // D-PHY, late lock, busy requests dropped (R4, R11, R13)
      pll_lock = 0; on_req = 1;
      cyc(CLKV, "R2");
      on_req = 0;
      cyc(WAITV, "R4");
      for (int k = 0; k < 9; k++) begin
         {on_req, off_req, init_req} = (k == 3) ? 3'b111 : 3'b000;
         if (k == 3) mode_lvds = 1;
         cyc(WAITV, "R11");
      end
      {on_req, off_req, init_req} = 3'b000;
      cyc(WAITV, "R4");           // sample at tick 10 sees no lock
      for (int k = 10; k < 29; k++) begin
         pll_lock = (k == 12 || k == 13 || k >= 20);
         cyc(WAITV, "R4");
      end
      pll_lock = 1;
      cyc(v(0,0,0,1,1,0), "R4");
      cyc(v(0,0,0,1,0,0), "R13");
      init_req = 1;
      cyc(v(1,1,0,0,1,0), "R10");
      init_req = 0; mode_lvds = 0;
      cyc(OFFV, "R10");

      // timeout (R5, R12)
      pll_lock = 0; on_req = 1;
      cyc(CLKV, "R2");
      on_req = 0;
      cyc(WAITV, "R5");
      hold(999, WAITV, "R5");
      cyc(v(1,1,0,0,0,1), "R5");
      hold(3, v(1,1,0,0,0,1), "R12");
      off_req = 1;
      cyc(v(1,1,0,0,1,1), "R12");
      off_req = 0;
      cyc(v(1,1,0,0,0,1), "R12");

      // lock at the final sample wins (R5), error cleared (R12)
      on_req = 1;
      cyc(CLKV, "R12");
      on_req = 0;
      cyc(WAITV, "R5");
      hold(999, WAITV, "R5");
      pll_lock = 1;
      cyc(v(0,0,0,1,1,0), "R5");
      cyc(v(0,0,0,1,0,0), "R5");
      off_req = 1;
      cyc(v(1,1,0,0,1,0), "R9");
      off_req = 0;
      cyc(OFFV, "R9");

      // LVDS master (R6, R7)
      mode_lvds = 1; slave_en = 0; pll_lock = 1; on_req = 1;
      cyc(CLKV, "R6");
      on_req = 0;
      cyc(v(1,1,1,1,0,0), "R6");
      cyc(v(1,0,1,1,0,0), "R6");
      cyc(v(0,0,1,1,0,0), "R6");
      hold(9, v(0,0,1,1,0,0), "R7");
      cyc(v(0,0,1,1,1,0), "R7");
      cyc(v(0,0,1,1,0,0), "R7");
      off_req = 1;
      cyc(v(1,1,0,0,1,0), "R9");
      off_req = 0;
      cyc(OFFV, "R9");

      // LVDS slave, lock never present (R8)
      slave_en = 1; pll_lock = 0; on_req = 1;
      cyc(CLKV, "R8");
      on_req = 0;
      cyc(v(1,1,1,1,0,0), "R8");
      cyc(v(1,0,1,1,0,0), "R8");
      cyc(v(0,0,1,1,1,0), "R8");
      hold(20, v(0,0,1,1,0,0), "R8");
      off_req = 1;
      cyc(v(1,1,0,0,1,0), "R9");
      off_req = 0;
      cyc(OFFV, "R9");

      while (exp_q.size() > 0) @(negedge clk);
      #1;
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule